// File: doc/BRIEF.md
# Signed Arithmetic Unit with Sign Condition Code

This block is a purely combinational arithmetic unit for a small 32-bit processor. It takes an operation code and two signed operands. It returns a 32-bit result and a 4-bit condition code that sorts that result into one of three classes: negative, zero or positive. A fourth class marks an arithmetic error. The sequencer writes the condition code into its condition register after arithmetic instructions. Later instructions compare their predicate mask against that register.

The same unit also forms addresses. Load and store operations add the two operands, and the sequencer uses the sum as a memory address. A halt operation yields a fixed zero. Addition, subtraction and multiplication wrap silently at 32 bits. Division rounds toward minus infinity. A zero divisor does not trap: it yields a zero result with only the error flag set.

Top module: `sign_flag_alu`

## Requirements
- R1: The condition code is one-hot. Bit 0 means negative, bit 1 means zero, bit 2 means positive and bit 3 means error. On every non-error result exactly one of bits 0 to 2 is set, chosen from the signed value of the result.
- R2: Opcode 3 (add) returns the two operands' sum, wrapped to 32 bits.
- R3: Opcode 5 (subtract) returns the first operand minus the second, wrapped to 32 bits.
- R4: Opcode 6 (multiply) returns the low 32 bits of the signed product. The flags are taken from that truncated value.
- R5: Opcode 7 (divide) returns the signed quotient rounded toward minus infinity. For example, 12 and -3 give -4, and 3 and 4 give 0 with the zero flag set.
- R6: Opcode 7 with a zero second operand returns 0 with only bit 3 set.
- R7: Opcodes 1 and 2 (load, store) return the wrapped sum of the operands as an address, with flags taken from it.
- R8: Opcode 0 (halt) returns 0 with only bit 1 set, whatever the operands are.
- R9: Opcodes 4 and 8 to 31 return 0 with only bit 3 set.
- R10: Opcode 7 with the most negative value divided by -1 returns the most negative value, wrapped, with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation selector |
| src_a | input | 32 | First signed operand (dividend, minuend) |
| src_b | input | 32 | Second signed operand (divisor, subtrahend) |
| result | output | 32 | Operation result |
| cond | output | 4 | One-hot condition code: negative, zero, positive, error |

## Verification
Two outcomes can produce the same zero result in the same evaluation: a genuine zero quotient and a divide-by-zero error. The bench places divisions with a zero divisor next to divisions whose true quotient is zero, such as 3 by 4 and 0 by -5. Each case is judged on the full condition code, so an error shown as zero, or a zero shown as an error, fails. The halt and undefined-opcode cases also return zero and are checked in the same way. Floor rounding and divisor sign are exercised together using operands of mixed sign with non-zero remainders.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 5;
    localparam int CC_W   = 4;

    // Condition code bit positions (the sequencer decodes these)
    localparam int CC_NEG  = 0;
    localparam int CC_ZERO = 1;
    localparam int CC_POS  = 2;
    localparam int CC_ERR  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 5'd0,
        OP_LOAD  = 5'd1,
        OP_STORE = 5'd2,
        OP_ADD   = 5'd3,
        OP_SUB   = 5'd5,
        OP_MUL   = 5'd6,
        OP_DIV   = 5'd7
    } op_e;

    typedef logic [CC_W-1:0] cc_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              err;
    } lane_t;

    function automatic cc_t cc_bit(input int idx);
        cc_t c;
        c = '0;
        c[idx] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod
);
    // Low W bits of a product are identical for signed and unsigned operands
    always_comb prod = a * b;
endmodule

// File: rtl/alu_floor_div.sv
module alu_floor_div #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic         div_zero
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic               wrap_case;
    logic signed [W-1:0] dvs;
    logic signed [W-1:0] q_trunc;
    logic signed [W-1:0] r_trunc;
    logic               adjust;

    always_comb begin
        div_zero  = (b == '0);
        wrap_case = (a == MOST_NEG) && (b == '1);
        // Keep the raw divider away from the two undefined cases
        dvs       = (div_zero || wrap_case) ? $signed(ONE) : $signed(b);
        q_trunc   = $signed(a) / dvs;
        r_trunc   = $signed(a) % dvs;
        adjust    = (r_trunc != '0) && (r_trunc[W-1] != dvs[W-1]);
        if (div_zero)       quot = '0;
        else if (wrap_case) quot = MOST_NEG;
        else                quot = q_trunc - (adjust ? ONE : '0);
    end

    // Floor property: remainder a - q*b is zero or shares the divisor's sign
    logic signed [2*W-1:0] wa, wb, wq, rem;
    always_comb begin
        wa  = {{W{a[W-1]}}, a};
        wb  = {{W{b[W-1]}}, b};
        wq  = {{W{quot[W-1]}}, quot};
        rem = wa - wq * wb;
        if (!div_zero && !wrap_case) begin
            assert_floor_rem_sign_R5: assert (rem == '0 || rem[2*W-1] == b[W-1])
                else $error("floor remainder sign");
            assert_floor_rem_mag_R5: assert ((rem[2*W-1] ? -rem : rem) < (wb[2*W-1] ? -wb : wb))
                else $error("floor remainder magnitude");
        end
    end
endmodule

// File: rtl/alu_flagger.sv
module alu_flagger
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         err,
    output cc_t          cc
);
    always_comb begin
        if (err)               cc = cc_bit(CC_ERR);
        else if (value == '0)  cc = cc_bit(CC_ZERO);
        else if (value[W-1])   cc = cc_bit(CC_NEG);
        else                   cc = cc_bit(CC_POS);
    end

    always_comb begin
        assert_cc_onehot_R1: assert ($onehot(cc)) else $error("cc not one-hot");
    end
endmodule

// File: rtl/sign_flag_alu.sv
module sign_flag_alu
    import alu_pkg::*;
(
    input  logic [4:0]  op_code,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic [31:0] result,
    output logic [3:0]  cond
);
    logic [DATA_W-1:0] sum, prod, quot;
    logic              div_zero, do_sub;
    lane_t             lane;
    cc_t               cc;

    assign do_sub = (op_code == OP_SUB);

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a(src_a), .b(src_b), .sub(do_sub), .sum(sum)
    );

    alu_mul #(.W(DATA_W)) u_mul (
        .a(src_a), .b(src_b), .prod(prod)
    );

    alu_floor_div #(.W(DATA_W)) u_div (
        .a(src_a), .b(src_b), .quot(quot), .div_zero(div_zero)
    );

    always_comb begin
        lane = '{value: '0, err: 1'b1};
        case (op_code)
            OP_HALT:                   lane = '{value: '0,   err: 1'b0};
            OP_LOAD, OP_STORE, OP_ADD,
            OP_SUB:                    lane = '{value: sum,  err: 1'b0};
            OP_MUL:                    lane = '{value: prod, err: 1'b0};
            OP_DIV:                    lane = '{value: quot, err: div_zero};
            default:                   lane = '{value: '0,   err: 1'b1};
        endcase
    end

    alu_flagger #(.W(DATA_W)) u_flag (
        .value(lane.value), .err(lane.err), .cc(cc)
    );

    assign result = lane.value;
    assign cond   = cc;

    always_comb begin
        if (!cond[CC_ERR]) begin
            assert_zero_flag_R1: assert (cond[CC_ZERO] == (result == '0))
                else $error("zero flag mismatch");
            assert_neg_flag_R1: assert (cond[CC_NEG] == result[DATA_W-1])
                else $error("negative flag mismatch");
        end
        if (cond[CC_ERR]) begin
            assert_err_zero_result_R6: assert (result == '0)
                else $error("error with non-zero result");
        end
        if (op_code == OP_DIV && src_b == '0) begin
            assert_div_zero_err_R6: assert (cond == cc_bit(CC_ERR))
                else $error("divide by zero not flagged");
        end
        if (op_code == 5'd4 || op_code > 5'd7) begin
            assert_bad_op_R9: assert (cond == cc_bit(CC_ERR) && result == '0)
                else $error("undefined opcode not flagged");
        end
        if (op_code == OP_HALT) begin
            assert_halt_zero_R8: assert (cond == cc_bit(CC_ZERO) && result == '0)
                else $error("halt not zero");
        end
    end
endmodule

// File: tb/test_sign_flag_alu.sv
module test_sign_flag_alu;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [4:0]  op_code = 5'd0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [31:0] result;
    logic [3:0]  cond;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sign_flag_alu i_sign_flag_alu (
        .op_code(op_code), .src_a(src_a), .src_b(src_b),
        .result(result), .cond(cond)
    );

    // Behavioural reference model
    function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic [3:0] c);
        longint la, lb, q, m;
        bit err;
        la = longint'($signed(a));
        lb = longint'($signed(b));
        err = 1'b0;
        r = '0;
        case (op)
            0: r = '0;
            1, 2, 3: r = 32'(la + lb);
            5: r = 32'(la - lb);
            6: r = 32'(la * lb);
            7: begin
                if (lb == 0) err = 1'b1;
                else begin
                    q = la / lb;
                    m = la % lb;
                    if (m != 0 && ((m < 0) != (lb < 0))) q = q - 1;
                    r = 32'(q);
                end
            end
            default: err = 1'b1;
        endcase
        if (err)                 c = 4'b1000;
        else if (r == 0)         c = 4'b0010;
        else if (r[31])          c = 4'b0001;
        else                     c = 4'b0100;
    endfunction

    task automatic apply(input string tag, input int op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [3:0]  ec;
        @(negedge clk);
        op_code = 5'(op);
        src_a   = a;
        src_b   = b;
        model(op, a, b, er, ec);
        @(posedge clk);
        #1;
        checks++;
        if (result !== er || cond !== ec) begin
            errors++;
            $display("FAIL %s op=%0d a=%0d b=%0d: result=%0d cond=%b expected result=%0d cond=%b",
                     tag, op, $signed(a), $signed(b), $signed(result), cond, $signed(er), ec);
        end
    endtask

    initial begin
        #200000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: inputs at zero -> halt opcode, zero result, Z flag (R8)
        apply("R8 reset", 0, 32'd0, 32'd0);
        // R2 add
        apply("R2", 3, 32'd5, 32'd3);
        apply("R2", 3, -32'sd5, 32'd3);
        apply("R1 R2", 3, -32'sd10, 32'd10);
        apply("R2 wrap", 3, 32'h7fffffff, 32'd1);
        // R3 subtract
        apply("R3", 5, 32'd5, 32'd3);
        apply("R3", 5, 32'd3, 32'd5);
        apply("R1 R3", 5, 32'd3, 32'd3);
        apply("R3 wrap", 5, 32'h80000000, 32'd1);
        // R4 multiply
        apply("R4", 6, 32'd3, 32'd5);
        apply("R4", 6, -32'sd3, 32'd5);
        apply("R4", 6, 32'd0, 32'd22);
        apply("R4 trunc", 6, 32'h00010000, 32'h00010000);
        apply("R4 trunc", 6, 32'h40000000, 32'd3);
        // R5 floor divide
        apply("R5", 7, 32'd5, 32'd3);
        apply("R5", 7, 32'd12, -32'sd3);
        apply("R5 zero", 7, 32'd3, 32'd4);
        apply("R5 floor", 7, -32'sd7, 32'd2);
        apply("R5 floor", 7, 32'd7, -32'sd2);
        apply("R5 floor", 7, -32'sd7, -32'sd2);
        apply("R5 floor", 7, -32'sd1, 32'd4);
        apply("R5 zero", 7, 32'd0, -32'sd5);
        // R6 divide by zero
        apply("R6", 7, 32'd12, 32'd0);
        apply("R6", 7, 32'd0, 32'd0);
        apply("R6", 7, -32'sd9, 32'd0);
        // R10 wrap case
        apply("R10", 7, 32'h80000000, 32'hffffffff);
        // R7 address
        apply("R7", 1, 32'd12, 32'd13);
        apply("R7", 2, 32'd27, 32'd13);
        apply("R7", 1, 32'd100, -32'sd100);
        apply("R7", 2, 32'd4, -32'sd8);
        // R8 halt
        apply("R8", 0, 32'd99, 32'd98);
        // R9 undefined opcodes
        apply("R9", 4, 32'd5, 32'd6);
        for (int op = 8; op < 32; op++) apply("R9", op, 32'd1, 32'd2);
        // Mixed operands across defined opcodes (R1)
        for (int i = 0; i < 120; i++) begin
            int ops[7] = '{0, 1, 2, 3, 5, 6, 7};
            logic [31:0] a, b;
            a = $urandom();
            b = $urandom();
            if (i % 4 == 0) b = b % 9 - 4;
            apply("R1 mixed", ops[i % 7], a, b);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule